// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block is a hardware master for the 16-bit configuration registers inside a PHY. Those registers have no address in any memory map. The only way to reach them is through a 20-bit control word that the block drives and a 17-bit status word that the block samples. Every move across that boundary uses a four-phase handshake. The block raises one strobe and waits until the PHY's acknowledge is seen high. It then removes the strobe and waits until the acknowledge is seen low. Only after that does the next step start.

A user presents one operation at a time: read or write, a 16-bit register address and, for writes, 16-bit data. The block accepts the request when it is idle. It steps through the address phase and then the data phase. It ends with a one-cycle done pulse that carries the read data or a timeout error.

The acknowledge is sampled at a fixed poll interval, with a bounded number of samples per wait. A PHY that never answers, or never releases, makes the block abort cleanly instead of hanging.

Top module: `phy_ireg_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `ctl_word`, `rsp_done` and `rsp_err` are 0.
- R2: `ctl_word` layout: bits 15:0 carry address or data, bit 16 captures the address, bit 17 captures data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is set at any time.
- R3: Each strobe word is held until the synchronized acknowledge (`stat_word[16]`, two flops) is sampled high. The following strobe-free word is held until the acknowledge is sampled low. Only then does the next strobe appear.
- R4: Every operation opens with the same three words: the address alone, then the address with bit 16, then the address alone again.
- R5: A write continues with these words in order: data with bit 17, data alone, bit 18 alone, data alone, and finally all zeros.
- R6: A read continues with bit 19 alone, then all zeros. `rsp_rdata` takes `stat_word[15:0]` at the poll where the acknowledge is seen high during the read strobe, and it is valid while `rsp_done` is high.
- R7: Within a wait, the acknowledge is sampled once every `POLL_GAP` cycles. The first sample comes `POLL_GAP` cycles after the step's word is driven, and each wait allows at most `POLL_MAX` (default 10) samples.
- R8: If the last allowed sample misses, `ctl_word` returns to 0 and `rsp_done` and `rsp_err` are both high for one cycle. When the first wait times out, done is visible after edge 2+10·`POLL_GAP` counted from the accepting edge (edge 1). When the second wait times out after a first-poll hit, done is visible after edge 2+11·`POLL_GAP`.
- R9: `req_ready` is high only when idle. A request raised while busy is ignored: it never reaches `ctl_word`, and once done it does not start on its own.
- R10: `rsp_done` lasts exactly one cycle, and `rsp_err` is 0 on a successful operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle and able to accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Timeout flag, valid with `rsp_done` |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| ctl_word | output | 20 | Control word toward the PHY |
| stat_word | input | 17 | Status from the PHY: [16] acknowledge, [15:0] read data |

## Verification
On the edge that accepts a request, the address word appears. The first strobe word follows one edge later. After that, every word change lands exactly on a poll, and polls fall on multiples of `POLL_GAP` counted from the step start. This makes the capture-address hold time exactly `POLL_GAP` for a PHY answering within the synchronizer delay, and exactly twice that for a PHY three cycles slower. Timeout completion is checked at the exact edge count given in R8. The bench counts rising edges from the accepting edge and samples every output on the falling edge that follows. It reads `rsp_rdata` and `rsp_err` only on the falling edge where `rsp_done` is high, and checks that done is low again one falling edge later.

// File: rtl/phy_ireg_pkg.sv
package phy_ireg_pkg;

  localparam int CTL_W   = 20;
  localparam int STAT_W  = 17;
  localparam int BUS_W   = 16;
  localparam int STEP_W  = 3;

  // strobe positions inside the control word (decoded by the PHY)
  localparam int B_CAP_ADDR = 16;
  localparam int B_CAP_DATA = 17;
  localparam int B_WRITE    = 18;
  localparam int B_READ     = 19;
  localparam int B_ACK      = 16;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_WAIT} seq_state_t;

  // index of the final handshake step for the operation
  function automatic logic [STEP_W-1:0] last_step(input logic is_wr);
    return is_wr ? STEP_W'(5) : STEP_W'(3);
  endfunction

  // even steps carry a strobe and wait for ack high; odd steps wait for low
  function automatic logic step_expect(input logic [STEP_W-1:0] step);
    return ~step[0];
  endfunction

  function automatic logic [CTL_W-1:0] strobe(input int pos);
    return CTL_W'(1) << pos;
  endfunction

  // control word driven during a given handshake step
  function automatic logic [CTL_W-1:0] step_word(input logic is_wr,
                                                 input logic [STEP_W-1:0] step,
                                                 input logic [BUS_W-1:0] addr,
                                                 input logic [BUS_W-1:0] data);
    logic [CTL_W-1:0] a, d;
    a = CTL_W'(addr);
    d = CTL_W'(data);
    case (step)
      3'd0:    return a | strobe(B_CAP_ADDR);
      3'd1:    return a;
      3'd2:    return is_wr ? (d | strobe(B_CAP_DATA)) : strobe(B_READ);
      3'd3:    return is_wr ? d : '0;
      3'd4:    return is_wr ? strobe(B_WRITE) : '0;
      3'd5:    return is_wr ? d : '0;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/phy_ireg_ack_sync.sv
module phy_ireg_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_sync
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sr_q[i] <= 1'b0;
        else if (i == 0) sr_q[i] <= d_in;
        else sr_q[i] <= sr_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_sync = sr_q[STAGES-1];
endmodule

// File: rtl/phy_ireg_poll_timer.sv
module phy_ireg_poll_timer #(
  parameter int GAP   = 100,
  parameter int POLLS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic poll_now,
  output logic last_poll
);
  localparam int GW = $clog2(GAP + 1);
  localparam int PW = $clog2(POLLS + 1);

  logic [GW-1:0] gap_q;
  logic [PW-1:0] cnt_q;

  assign poll_now  = run && (gap_q == GW'(GAP - 1));
  assign last_poll = (cnt_q == PW'(POLLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      cnt_q <= '0;
    end else if (restart) begin
      gap_q <= '0;
      cnt_q <= '0;
    end else if (poll_now) begin
      gap_q <= '0;
      cnt_q <= cnt_q + PW'(1);
    end else if (run) begin
      gap_q <= gap_q + GW'(1);
    end
  end
endmodule

// File: rtl/phy_ireg_seq.sv
module phy_ireg_seq
  import phy_ireg_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int POLL_GAP    = CLK_MHZ,
  parameter int POLL_MAX    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        req_ready,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic [15:0] rsp_rdata,
  output logic [19:0] ctl_word,
  input  logic [16:0] stat_word
);
  seq_state_t        state_q;
  logic [STEP_W-1:0] step_q;
  logic              op_wr_q;
  logic [BUS_W-1:0]  addr_q, data_q, rdata_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              done_q, err_q;

  // named internal events
  logic ack_s, poll_now, last_poll;
  logic accept, timer_restart, poll_hit, poll_miss;
  logic step_adv, seq_end, timeout_ev, rd_latch;

  phy_ireg_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(stat_word[B_ACK]), .d_sync(ack_s)
  );

  phy_ireg_poll_timer #(.GAP(POLL_GAP), .POLLS(POLL_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(timer_restart),
    .run(state_q == S_WAIT), .poll_now(poll_now), .last_poll(last_poll)
  );

  assign accept        = (state_q == S_IDLE) && req_valid;
  assign poll_hit      = poll_now && (ack_s == step_expect(step_q));
  assign poll_miss     = poll_now && !poll_hit;
  assign timeout_ev    = poll_miss && last_poll;
  assign step_adv      = poll_hit && (step_q != last_step(op_wr_q));
  assign seq_end       = poll_hit && (step_q == last_step(op_wr_q));
  assign rd_latch      = poll_hit && !op_wr_q && (step_q == STEP_W'(2));
  assign timer_restart = (state_q == S_PRE) || step_adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      op_wr_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      ctl_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          op_wr_q <= req_write;
          addr_q  <= req_addr;
          data_q  <= req_wdata;
          ctl_q   <= CTL_W'(req_addr);
          state_q <= S_PRE;
        end
        S_PRE: begin
          ctl_q   <= step_word(op_wr_q, '0, addr_q, data_q);
          step_q  <= '0;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (rd_latch) rdata_q <= stat_word[BUS_W-1:0];
          if (step_adv) begin
            step_q <= step_q + STEP_W'(1);
            ctl_q  <= step_word(op_wr_q, step_q + STEP_W'(1), addr_q, data_q);
          end else if (seq_end || timeout_ev) begin
            ctl_q   <= '0;
            done_q  <= 1'b1;
            err_q   <= timeout_ev;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign ctl_word  = ctl_q;
endmodule

// File: rtl/phy_ireg_seq_chk.sv
module phy_ireg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic [19:0] ctl_word,
  input logic        accept,
  input logic        timeout_ev
);
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_word[19:16]));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ctl_word == 20'h0));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r8_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  a_r8_timeout_abort: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> (rsp_err && rsp_done && ctl_word == 20'h0));
endmodule

bind phy_ireg_seq phy_ireg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .rsp_err(rsp_err), .ctl_word(ctl_word), .accept(accept),
  .timeout_ev(timeout_ev)
);

// File: tb/phy_ireg_seq_tb.sv
module phy_ireg_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [19:0] ctl_word;
  logic [16:0] stat_word;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_ireg_seq #(.POLL_GAP(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ctl_word(ctl_word), .stat_word(stat_word)
  );

  // behavioural PHY on the far side of the handshake
  int          phy_lat = 3;
  bit          mute = 0, force_hi = 0;
  logic        ack;
  logic [15:0] rd_q, cap_a, cap_d;
  logic [15:0] regs [8];
  logic [3:0]  prev_str;
  int          lcnt;
  wire         tgt = |ctl_word[19:16];

  assign stat_word = {ack, rd_q};

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 0; rd_q <= 0; cap_a <= 0; cap_d <= 0; prev_str <= 0; lcnt <= 0;
      for (int i = 0; i < 8; i++) regs[i] <= 16'h0;
    end else begin
      if (ctl_word[16] && !prev_str[0]) cap_a <= ctl_word[15:0];
      if (ctl_word[17] && !prev_str[1]) cap_d <= ctl_word[15:0];
      if (ctl_word[18] && !prev_str[2]) regs[cap_a[2:0]] <= cap_d;
      if (ctl_word[19] && !prev_str[3]) rd_q <= regs[cap_a[2:0]];
      prev_str <= ctl_word[19:16];
      if (force_hi) ack <= 1;
      else if (mute) ack <= 0;
      else if (ack == tgt) lcnt <= 0;
      else if (lcnt >= phy_lat) begin ack <= tgt; lcnt <= 0; end
      else lcnt <= lcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one operation: counts edges from the accepting edge (edge 1)
  logic [19:0] log_w [16];
  int          log_n;
  int          n_done, capa_cyc;
  bit          r_err, busy_ready;
  logic [15:0] r_data;

  task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input int poke_at);
    logic [19:0] last;
    bit got = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    log_n = 0; last = ctl_word; n_done = 0; capa_cyc = 0; busy_ready = 0;
    while (!got && n_done < 5000) begin
      @(posedge clk);
      n_done++;
      @(negedge clk);
      if (n_done == 1) req_valid = 0;
      if (n_done == poke_at) begin
        busy_ready = req_ready;
        req_valid = 1; req_write = 0; req_addr = 16'h0001;
      end else if (n_done == poke_at + 1) req_valid = 0;
      if (ctl_word != last) begin
        if (log_n < 16) log_w[log_n] = ctl_word;
        log_n++;
        last = ctl_word;
      end
      if (ctl_word[16]) capa_cyc++;
      if (rsp_done) begin got = 1; r_err = rsp_err; r_data = rsp_rdata; end
    end
    chk("R10 done seen", 32'(got), 32'd1);
    @(negedge clk);
    chk("R10 done one cycle", 32'(rsp_done), 32'd0);
  endtask

  task automatic chk_log(input string req, input bit wr, input logic [15:0] a,
                         input logic [15:0] d);
    logic [19:0] e [8];
    int en;
    e[0] = {4'h0, a}; e[1] = {4'h1, a}; e[2] = {4'h0, a};
    if (wr) begin
      e[3] = {4'h2, d}; e[4] = {4'h0, d}; e[5] = 20'h40000; e[6] = {4'h0, d};
      e[7] = 20'h0; en = 8;
    end else begin
      e[3] = 20'h80000; e[4] = 20'h0; en = 5;
    end
    chk({req, " word count"}, 32'(log_n), 32'(en));
    for (int i = 0; i < en && i < log_n; i++)
      chk({req, " word order"}, 32'(log_w[i]), 32'(e[i]));
  endtask

  task automatic t_reset();
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 ctl", 32'(ctl_word), 32'd0);
    chk("R1 done", 32'(rsp_done), 32'd0);
    chk("R1 err", 32'(rsp_err), 32'd0);
  endtask

  task automatic t_write_slow();
    phy_lat = 3;
    run_op(1, 16'h0005, 16'hA5C3, -10);
    chk_log("R4 R5 write", 1, 16'h0005, 16'hA5C3);
    chk("R10 no err", 32'(r_err), 32'd0);
    chk("R7 capture hold slow", 32'(capa_cyc), 32'(2*G));
    chk("R3 R5 reg written", 32'(regs[5]), 32'hA5C3);
  endtask

  task automatic t_read_slow();
    run_op(0, 16'h0005, 16'h0, -10);
    chk_log("R4 R6 read", 0, 16'h0005, 16'h0);
    chk("R6 rdata", 32'(r_data), 32'hA5C3);
    chk("R10 no err", 32'(r_err), 32'd0);
  endtask

  task automatic t_fast_phy();
    phy_lat = 0;
    run_op(1, 16'h0002, 16'h1234, -10);
    chk("R7 capture hold fast", 32'(capa_cyc), 32'(G));
    chk_log("R2 R5 write fast", 1, 16'h0002, 16'h1234);
    run_op(0, 16'h0002, 16'h0, -10);
    chk("R6 rdata fast", 32'(r_data), 32'h1234);
    phy_lat = 3;
  endtask

  task automatic t_timeout_mute();
    mute = 1;
    run_op(1, 16'h0007, 16'hBEEF, -10);
    chk("R8 err", 32'(r_err), 32'd1);
    chk("R8 timing first wait", 32'(n_done), 32'(2 + 10*G));
    chk("R8 ctl cleared", 32'(ctl_word), 32'd0);
    chk("R8 last word", 32'(log_w[log_n-1]), 32'd0);
    chk("R8 ready again", 32'(req_ready), 32'd1);
    mute = 0;
    repeat (4) @(negedge clk);
    chk("R8 phy untouched", 32'(regs[7]), 32'd0);
  endtask

  task automatic t_stuck_high();
    force_hi = 1;
    repeat (4) @(negedge clk);
    run_op(0, 16'h0003, 16'h0, -10);
    chk("R8 err stuck", 32'(r_err), 32'd1);
    chk("R8 timing second wait", 32'(n_done), 32'(2 + 11*G));
    force_hi = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    run_op(1, 16'h0006, 16'h0F0F, 5);
    chk("R9 not ready while busy", 32'(busy_ready), 32'd0);
    chk_log("R9 busy write", 1, 16'h0006, 16'h0F0F);
    repeat (5) @(negedge clk);
    chk("R9 no late start", 32'(ctl_word), 32'd0);
    chk("R9 idle", 32'(req_ready), 32'd1);
    run_op(0, 16'h0006, 16'h0, -10);
    chk("R9 R6 readback", 32'(r_data), 32'h0F0F);
    run_op(0, 16'h0005, 16'h0, -10);
    chk("R3 recovered read", 32'(r_data), 32'hA5C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_slow();
    t_read_slow();
    t_fast_phy();
    t_timeout_mute();
    t_stuck_high();
    t_busy_ignore();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule